// File: doc/BRIEF.md
# SIR Infrared Pulse Encoder

This block turns a stream of bytes into the optical pulse train of a serial infrared link at the slow (SIR) rates. Each byte offered on a valid/ready input is wrapped in an asynchronous-serial frame: a start bit, the eight data bits least significant first, and a stop bit. Every bit that is 0 becomes one short light pulse at the start of its bit cell. Every bit that is 1 leaves the emitter dark.

All timing comes from one clock, nominally 48 MHz. The bit period is set by a fractional phase accumulator, so rates that do not divide the clock evenly still hold the right average period. A mode input selects the pulse width. It is either three sixteenths of the bit period, or a short programmable width counted in clock periods that does not change with the rate. The configuration is sampled when a frame starts from idle. Bytes offered back to back follow each other with no idle gap.

Top module: `sir_pulse_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `ir_tx` and `busy` are low and `in_ready` is high.
- R2: An accepted byte is sent as ten bit cells: a 0 start bit, then data bits 0 to 7 in that order, then a 1 stop bit. A 0 cell carries exactly one high pulse that begins at its first clock. A 1 cell keeps `ir_tx` low for the whole cell.
- R3: `rate_sel` codes 0, 1, 2, 3 and 4 select 9600, 19200, 38400, 57600 and 115200 bit/s, and codes 5 to 7 also select 115200. With B the rate and F the clock frequency, clock n of a frame (n = 0 is the clock after the accepting edge) lies in cell floor(n*B/F), so cell k starts at clock ceil(k*F/B).
- R4: With `fixed_mode` = 0, each pulse lasts floor(3*F/(16*B)) clocks.
- R5: With `fixed_mode` = 1, each pulse lasts `fixed_width`+1 clocks, limited to floor(F/B) clocks.
- R6: `busy` is high from clock 0 of a frame through the last clock of its stop cell. During that span `in_ready` is low except in the last clock of the stop cell.
- R7: A byte accepted in the last clock of a stop cell starts its start cell on the next clock, and the cell timing continues without a restart, as cells 10 to 19 of the same grid.
- R8: Rate, mode and width are sampled only when a byte is accepted from idle. Changes while a frame is in progress, and at a back-to-back acceptance, have no effect on the frames in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (48 MHz by default) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | A byte can be accepted this clock |
| rate_sel | input | 3 | Bit rate code |
| fixed_mode | input | 1 | 0: pulse is 3/16 of the bit period; 1: programmed width |
| fixed_width | input | 5 | Programmed pulse width minus one, in clocks |
| busy | output | 1 | A frame is in progress |
| ir_tx | output | 1 | Optical pulse output, high means light |

## Verification
Every rate code, including an unused one, is swept in both pulse modes. The data patterns are all zeros, all ones and alternating bits, so pulse positions are told apart from the bit order and from a start or stop bit that is swapped. Programmed widths at both ends of the field show whether the clip to the bit period at the top rate is applied, and whether a width of one clock is kept. Back-to-back pairs, with the configuration disturbed in the middle of a frame, show whether the cell grid continues unbroken and whether the configuration is held at the byte boundary.

// File: rtl/sir_tx_pkg.sv
package sir_tx_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int MIN_BAUD   = 9600;
  localparam int MAX_BAUD   = 115200;

  typedef struct packed {
    logic [2:0] rate;
    logic       fixed;
    logic [4:0] fw;
  } sir_cfg_t;

  // rate code to bit/s; unused codes fall to the top rate
  function automatic int baud_of(input logic [2:0] code);
    case (code)
      3'd0:    return 9600;
      3'd1:    return 19200;
      3'd2:    return 38400;
      3'd3:    return 57600;
      default: return MAX_BAUD;
    endcase
  endfunction

  // whole clocks that always fit in one bit cell
  function automatic int cell_floor(input int clk_hz, input int baud);
    return clk_hz / baud;
  endfunction

  // three sixteenths of the bit period, rounded down
  function automatic int prop_width(input int clk_hz, input int baud);
    return (3 * clk_hz) / (16 * baud);
  endfunction

  function automatic int pulse_width(input int clk_hz, input int baud,
                                     input logic fixed, input logic [4:0] fw);
    int req;
    int lim;
    if (!fixed) return prop_width(clk_hz, baud);
    req = int'(fw) + 1;
    lim = cell_floor(clk_hz, baud);
    return (req < lim) ? req : lim;
  endfunction
endpackage

// File: rtl/sir_cell_timer.sv
module sir_cell_timer #(
  parameter int CLK_HZ = 48_000_000,
  parameter int ACC_W  = 26,
  parameter int OFF_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [ACC_W-1:0] baud,
  output logic             cell_end,
  output logic [OFF_W-1:0] cell_off
);
  localparam logic [ACC_W:0] CLK_V = (ACC_W+1)'(CLK_HZ);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_next;

  assign sum      = {1'b0, acc_q} + {1'b0, baud};
  assign cell_end = run && (sum >= CLK_V);
  assign acc_next = cell_end ? ACC_W'(sum - CLK_V) : ACC_W'(sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      cell_off <= '0;
    end else if (restart) begin
      acc_q    <= '0;
      cell_off <= '0;
    end else if (run) begin
      acc_q    <= acc_next;
      cell_off <= cell_end ? '0 : cell_off + OFF_W'(1);
    end
  end

  // R3
  cell_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (longint'(cell_off) * longint'(baud)) < longint'(CLK_HZ));
endmodule

// File: rtl/sir_frame_seq.sv
module sir_frame_seq
  import sir_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DATA_BITS-1:0] in_data,
  input  sir_cfg_t             cfg_in,
  input  logic                 cell_end,
  output logic                 in_ready,
  output logic                 busy,
  output logic                 fresh_start,
  output logic                 cur_bit,
  output sir_cfg_t             cfg_q
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shreg;
  logic [IDX_W-1:0]      idx_q;
  logic                  last_cell;
  logic                  accept;

  assign last_cell   = busy && (idx_q == LAST) && cell_end;
  assign in_ready    = !busy || last_cell;
  assign accept      = in_valid && in_ready;
  assign fresh_start = accept && !busy;
  assign cur_bit     = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx_q <= '0;
      shreg <= '1;
      cfg_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      idx_q <= '0;
      shreg <= {1'b1, in_data, 1'b0};
      if (!busy) cfg_q <= cfg_in;
    end else if (busy && cell_end) begin
      if (idx_q == LAST) begin
        busy <= 1'b0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
        shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
      end
    end
  end

  // R7
  accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && (idx_q == '0) && !cur_bit);
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> cfg_q == $past(cfg_q));
  // R2
  stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (idx_q == LAST) |-> cur_bit);
endmodule

// File: rtl/sir_pulse_gen.sv
module sir_pulse_gen #(
  parameter int OFF_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             cur_bit,
  input  logic [OFF_W-1:0] cell_off,
  input  logic [OFF_W-1:0] width,
  output logic             ir_tx
);
  assign ir_tx = busy && !cur_bit && (cell_off < width);

  // R1
  idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !ir_tx);
  // R2
  pulse_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_tx) |-> cell_off == '0);
endmodule

// File: rtl/sir_pulse_tx.sv
module sir_pulse_tx
  import sir_tx_pkg::*;
#(
  parameter int CLK_HZ = 48_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DATA_BITS-1:0] in_data,
  output logic                 in_ready,
  input  logic [2:0]           rate_sel,
  input  logic                 fixed_mode,
  input  logic [4:0]           fixed_width,
  output logic                 busy,
  output logic                 ir_tx
);
  localparam int ACC_W = $clog2(CLK_HZ + MAX_BAUD);
  localparam int OFF_W = $clog2(CLK_HZ / MIN_BAUD + 1);

  sir_cfg_t         cfg_in;
  sir_cfg_t         cfg_q;
  logic             fresh_start;
  logic             cell_end;
  logic             cur_bit;
  logic [OFF_W-1:0] cell_off;
  logic [ACC_W-1:0] baud_v;
  logic [OFF_W-1:0] width_v;

  assign cfg_in  = '{rate: rate_sel, fixed: fixed_mode, fw: fixed_width};
  assign baud_v  = ACC_W'(baud_of(cfg_q.rate));
  assign width_v = OFF_W'(pulse_width(CLK_HZ, baud_of(cfg_q.rate),
                                      cfg_q.fixed, cfg_q.fw));

  sir_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_in(cfg_in), .cell_end(cell_end), .in_ready(in_ready),
    .busy(busy), .fresh_start(fresh_start), .cur_bit(cur_bit), .cfg_q(cfg_q)
  );

  sir_cell_timer #(.CLK_HZ(CLK_HZ), .ACC_W(ACC_W), .OFF_W(OFF_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(fresh_start), .run(busy),
    .baud(baud_v), .cell_end(cell_end), .cell_off(cell_off)
  );

  sir_pulse_gen #(.OFF_W(OFF_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cur_bit(cur_bit),
    .cell_off(cell_off), .width(width_v), .ir_tx(ir_tx)
  );

  // R6
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !in_ready |=> busy);
  // R7
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && in_ready && in_valid |=> busy && !in_ready);
endmodule

// File: tb/tb_sir_pulse_tx.sv
`timescale 1ns/1ps
module tb_sir_pulse_tx;
  localparam longint F = 2_400_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic [2:0] rate_sel = '0;
  logic       fixed_mode = 1'b0;
  logic [4:0] fixed_width = '0;
  logic       busy;
  logic       ir_tx;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sir_pulse_tx #(.CLK_HZ(2_400_000)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rate_sel(rate_sel), .fixed_mode(fixed_mode),
    .fixed_width(fixed_width), .busy(busy), .ir_tx(ir_tx)
  );

  function automatic longint rate_bps(input int code);
    case (code)
      0: return 9600;
      1: return 19200;
      2: return 38400;
      3: return 57600;
      default: return 115200;
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", what, got, exp);
    end
  endtask

  // one frame, or two back-to-back; every clock compared to the R2..R8 formulas
  task automatic run_case(input int sel, input bit mode, input logic [4:0] fw,
                          input logic [7:0] d0, input logic [7:0] d1, input bit two);
    longint b = rate_bps(sel);
    longint cells = two ? 20 : 10;
    longint end1 = (10 * F + b - 1) / b - 1;
    longint endc = (cells * F + b - 1) / b - 1;
    longint w;
    int e_tx = 0, e_bz = 0, e_rd = 0;
    int g_tx = 0, x_tx = 0, at_tx = 0;
    int g_rd = 0, x_rd = 0, at_rd = 0;
    if (mode) w = ((longint'(fw) + 1) < F / b) ? longint'(fw) + 1 : F / b;
    else      w = (3 * F) / (16 * b);
    @(negedge clk);
    rate_sel = 3'(sel); fixed_mode = mode; fixed_width = fw;
    in_data = d0; in_valid = 1'b1;
    @(posedge clk);
    for (longint n = 0; n <= endc + 3; n++) begin
      bit xt, xb, xr;
      @(negedge clk);
      xb = (n <= endc);
      xr = (n == end1) || (n >= endc);
      xt = 1'b0;
      if (n <= endc) begin
        longint k = (n * b) / F;
        longint st = (k * F + b - 1) / b;
        longint pos = k % 10;
        logic [7:0] by = (k < 10) ? d0 : d1;
        bit bv = (pos == 0) ? 1'b0 : (pos == 9) ? 1'b1 : by[pos-1];
        xt = !bv && ((n - st) < w);
      end
      if (ir_tx !== xt) begin
        if (e_tx == 0) begin g_tx = int'(ir_tx); x_tx = int'(xt); at_tx = int'(n); end
        e_tx++;
      end
      if (busy !== xb) e_bz++;
      if (in_ready !== xr) begin
        if (e_rd == 0) begin g_rd = int'(in_ready); x_rd = int'(xr); at_rd = int'(n); end
        e_rd++;
      end
      if (n == 0 && !two) in_valid = 1'b0;
      if (n == 0 && two) in_data = d1;
      if (two && n == end1 + 1) in_valid = 1'b0;
      if (n == 3) begin  // R8: disturb configuration mid-frame
        rate_sel = 3'((sel + 2) % 6); fixed_mode = !mode; fixed_width = ~fw;
      end
    end
    chk(e_tx == 0, $sformatf("R2 R3 R4 R5 R8 ir_tx sel=%0d mode=%0d fw=%0d two=%0d clock=%0d",
        sel, mode, fw, two, at_tx), g_tx, x_tx);
    chk(e_bz == 0, $sformatf("R6 busy mismatches sel=%0d two=%0d", sel, two), e_bz, 0);
    chk(e_rd == 0, $sformatf("R6 R7 in_ready sel=%0d two=%0d clock=%0d", sel, two, at_rd),
        g_rd, x_rd);
  endtask

  initial begin
    #750000;
    bad++;
    $display("FAIL R1 watchdog got=timeout exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ir_tx === 1'b0, "R1 ir_tx in reset", int'(ir_tx), 0);
    chk(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(in_ready === 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ir_tx === 1'b0 && busy === 1'b0, "R1 idle after reset", int'({busy, ir_tx}), 0);
    for (int sel = 0; sel < 6; sel++) begin
      run_case(sel, 1'b0, 5'd0,  8'h00, 8'h00, 1'b0);  // R4
      run_case(sel, 1'b0, 5'd9,  8'hA5, 8'h3C, 1'b1);  // R7
      run_case(sel, 1'b1, 5'd0,  8'h5A, 8'h00, 1'b0);  // R5 minimum
      run_case(sel, 1'b1, 5'd31, 8'hFF, 8'h01, 1'b1);  // R5 clip at top rate
      run_case(sel, 1'b1, 5'd13, 8'h96, 8'h00, 1'b0);
    end
    repeat (5) @(negedge clk);
    chk(ir_tx === 1'b0 && busy === 1'b0 && in_ready === 1'b1, "R1 idle at end",
        int'({in_ready, busy, ir_tx}), 4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule